// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recent page mappings and turns a virtual address into a physical address within the same cycle. Pages are fixed at 4 KB. The low 12 bits of the address pass through unchanged. Only the virtual page number is looked up, and it is compared against every stored entry at once. Each entry stores a valid flag, the virtual page number, the physical page number, a use flag and a modified flag.

A lookup that finds no entry raises a miss exception in the same cycle. The access can then be held back, the handler can install the mapping through the fill port, and the access can be retried. A lookup that hits marks its entry as used. A hitting write also marks the entry as modified. The status bits of the matched entry are returned alongside the translation. A clear input zeroes every use flag. On a fill, the entry to replace is chosen from the use flags, which approximates least-recently-used replacement.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `lk_paddr[11:0]` equals `lk_vaddr[11:0]`, and the upper bits of `lk_paddr` are the stored physical page number of the matching entry.
- R2: The virtual page number `lk_vaddr[VA_W-1:12]` is compared against all valid entries. A match in any entry position produces a hit.
- R3: When `lk_valid` is 1 and no valid entry matches, the block does four things: `lk_miss_exc` is 1, `lk_hit` is 0, `lk_paddr`, `lk_ref` and `lk_dirty` are 0, and no use or modified flag changes because of that access.
- R4: A hitting lookup sets the use flag of the matched entry from the next cycle on. `lk_ref` reports the flag as it was before the access.
- R5: A hitting lookup with `lk_write`=1 sets the modified flag of the entry from the next cycle on. A read leaves that flag unchanged. `lk_dirty` reports the flag as it was before the access.
- R6: `ref_clear`=1 zeroes every use flag at the next edge. A hit in the same cycle still leaves its own entry's use flag at 1.
- R7: A fill whose page is not already held goes to the lowest-numbered invalid entry when one exists. The rotating pointer does not move.
- R8: When every entry is valid, a fill goes to the first entry with use flag 0, scanning upward from the rotating pointer with wrap-around. The pointer then becomes victim+1, modulo ENTRIES.
- R9: When every entry is valid and every use flag is 1, a fill goes to the entry at the rotating pointer. The pointer then becomes victim+1.
- R10: A fill whose virtual page number matches a valid entry overwrites that entry, so a page is never held twice. The pointer does not move.
- R11: A filled entry starts with use and modified flags at 0. This holds even when a lookup hits that same entry in the fill cycle. Lookups see the state from before the fill.
- R12: After reset, every entry is invalid, the rotating pointer is 0, and every lookup misses.
- R13: `lk_hit`, `lk_miss_exc`, `lk_paddr`, `lk_ref` and `lk_dirty` depend combinationally on the current inputs and the stored state. With `lk_valid`=0, all of them are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_write | input | 1 | The lookup is a write access |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss_exc | output | 1 | Miss exception, so the access must not complete |
| lk_paddr | output | PA_W | Translated physical address, 0 on miss |
| lk_ref | output | 1 | Use flag of the matched entry before this access |
| lk_dirty | output | 1 | Modified flag of the matched entry before this access |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | VA_W-12 | Virtual page number to install |
| fill_ppn | input | PA_W-12 | Physical page number to install |
| ref_clear | input | 1 | Zero every use flag |

## Verification
The hardest state to reach from the ports is a full buffer in which the use flags have a chosen pattern and the rotating pointer sits away from entry 0. Only that state shows whether the replacement scan wraps and skips correctly. The stimulus gets there in stages. It fills every entry, touches all of them, and forces a pointer-based eviction. It then clears the use flags while touching one entry, re-touches a run of entries just above the pointer, and fills again, so the scan must pass over several used entries. A long random phase follows over a small page space, so that refills of held pages, fills colliding with same-cycle lookups, and clears all occur. Every cycle is compared against a behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned PAGE_OFS_W = 12;

    // How a fill picked its destination entry
    typedef enum logic [1:0] {
        FK_MATCH = 2'd0,   // page already present, overwrite in place
        FK_EMPTY = 2'd1,   // first invalid entry
        FK_UNREF = 2'd2,   // first unused entry scanning from pointer
        FK_PTR   = 2'd3    // every entry used, take pointer entry
    } fill_kind_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int unsigned N  = 16,
    parameter int unsigned KW = 20,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][KW-1:0] tags,
    input  logic [KW-1:0]        key,
    output logic [N-1:0]         hit_vec,
    output logic                 any,
    output logic [IW-1:0]        idx
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit_vec[g] = valid[g] && (tags[g] == key);
        end
    endgenerate

    assign any = |hit_vec;

    // Encoder: at most one bit is set, so OR-ing indices is exact
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int unsigned N = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  refb,
    input  logic [IW-1:0] ptr,
    input  logic          match_any,
    input  logic [IW-1:0] match_idx,
    output logic [IW-1:0] victim,
    output fill_kind_e    kind
);

    logic          empty_found;
    logic [IW-1:0] empty_idx;
    logic          unref_found;
    logic [IW-1:0] unref_idx;
    logic [IW-1:0] scan_pos;

    // Lowest invalid entry
    always_comb begin
        empty_found = 1'b0;
        empty_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !empty_found) begin
                empty_found = 1'b1;
                empty_idx   = IW'(i);
            end
        end
    end

    // First unused entry, scanning upward from the pointer with wrap
    always_comb begin
        unref_found = 1'b0;
        unref_idx   = ptr;
        scan_pos    = ptr;
        for (int k = 0; k < N; k++) begin
            scan_pos = ptr + IW'(k);
            if (!refb[scan_pos] && !unref_found) begin
                unref_found = 1'b1;
                unref_idx   = scan_pos;
            end
        end
    end

    always_comb begin
        if (match_any) begin
            victim = match_idx;
            kind   = FK_MATCH;
        end else if (empty_found) begin
            victim = empty_idx;
            kind   = FK_EMPTY;
        end else if (unref_found) begin
            victim = unref_idx;
            kind   = FK_UNREF;
        end else begin
            victim = ptr;
            kind   = FK_PTR;
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic                       lk_write,
    input  logic [VA_W-1:0]            lk_vaddr,
    output logic                       lk_hit,
    output logic                       lk_miss_exc,
    output logic [PA_W-1:0]            lk_paddr,
    output logic                       lk_ref,
    output logic                       lk_dirty,
    input  logic                       fill_valid,
    input  logic [VA_W-PAGE_OFS_W-1:0] fill_vpn,
    input  logic [PA_W-PAGE_OFS_W-1:0] fill_ppn,
    input  logic                       ref_clear
);

    localparam int unsigned VPN_W = VA_W - PAGE_OFS_W;
    localparam int unsigned PPN_W = PA_W - PAGE_OFS_W;
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            refb;
        logic [ENTRIES-1:0]            dirty;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [IDX_W-1:0]              ptr;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_vec;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic [ENTRIES-1:0] fill_vec;
    logic               fill_any;
    logic [IDX_W-1:0]   fill_idx;
    logic [IDX_W-1:0]   vic_idx;
    fill_kind_e         vic_kind;

    tlb_cam #(.N(ENTRIES), .KW(VPN_W)) u_lk_cam (
        .valid   (st_q.valid),
        .tags    (st_q.tag),
        .key     (lk_vaddr[VA_W-1:PAGE_OFS_W]),
        .hit_vec (lk_vec),
        .any     (lk_any),
        .idx     (lk_idx)
    );

    tlb_cam #(.N(ENTRIES), .KW(VPN_W)) u_fill_cam (
        .valid   (st_q.valid),
        .tags    (st_q.tag),
        .key     (fill_vpn),
        .hit_vec (fill_vec),
        .any     (fill_any),
        .idx     (fill_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid     (st_q.valid),
        .refb      (st_q.refb),
        .ptr       (st_q.ptr),
        .match_any (fill_any),
        .match_idx (fill_idx),
        .victim    (vic_idx),
        .kind      (vic_kind)
    );

    // Lookup outputs, combinational from inputs and state
    always_comb begin
        lk_hit      = lk_valid && lk_any;
        lk_miss_exc = lk_valid && !lk_any;
        lk_paddr    = '0;
        lk_ref      = 1'b0;
        lk_dirty    = 1'b0;
        if (lk_hit) begin
            lk_paddr = {st_q.ppn[lk_idx], lk_vaddr[PAGE_OFS_W-1:0]};
            lk_ref   = st_q.refb[lk_idx];
            lk_dirty = st_q.dirty[lk_idx];
        end
    end

    // Next state: clear, then access marks, then fill overrides its entry
    always_comb begin
        st_d = st_q;
        if (ref_clear) begin
            st_d.refb = '0;
        end
        if (lk_hit) begin
            st_d.refb[lk_idx] = 1'b1;
            if (lk_write) begin
                st_d.dirty[lk_idx] = 1'b1;
            end
        end
        if (fill_valid) begin
            st_d.valid[vic_idx] = 1'b1;
            st_d.tag[vic_idx]   = fill_vpn;
            st_d.ppn[vic_idx]   = fill_ppn;
            st_d.refb[vic_idx]  = 1'b0;
            st_d.dirty[vic_idx] = 1'b0;
            if (vic_kind == FK_UNREF || vic_kind == FK_PTR) begin
                st_d.ptr = vic_idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_DUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec)); // R10

    AST_REF_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !(fill_valid && vic_idx == lk_idx)) |=> st_q.refb[$past(lk_idx)]); // R4

    AST_DIRTY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_write && !(fill_valid && vic_idx == lk_idx)) |=> st_q.dirty[$past(lk_idx)]); // R5

    AST_MISS_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss_exc && !fill_valid && !ref_clear) |=> ($stable(st_q.refb) && $stable(st_q.dirty))); // R3

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_clear && !lk_hit && !fill_valid) |=> (st_q.refb == '0)); // R6

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (st_q.valid[$past(vic_idx)] && st_q.tag[$past(vic_idx)] == $past(fill_vpn)
                        && !st_q.refb[$past(vic_idx)])); // R11

endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss_exc, lk_ref, lk_dirty;
    logic [31:0] lk_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        ref_clear = 1'b0;

    int checks = 0;
    int errors = 0;

    // behavioural model
    bit          mv[N];
    logic [19:0] mtag[N];
    logic [19:0] mppn[N];
    bit          mref[N];
    bit          mdirty[N];
    int          mptr;

    always #2 clk = ~clk;

    tlb_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss_exc(lk_miss_exc), .lk_paddr(lk_paddr),
        .lk_ref(lk_ref), .lk_dirty(lk_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .ref_clear(ref_clear)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit lv, bit lw, logic [31:0] va,
                        bit fv, logic [19:0] fvpn, logic [19:0] fppn, bit rc);
        int mi, fi, vic, kind;
        bit eh;
        logic [31:0] ep;
        lk_valid = lv; lk_write = lw; lk_vaddr = va;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; ref_clear = rc;
        #1;
        mi = -1;
        for (int i = 0; i < N; i++) if (mv[i] && mtag[i] == va[31:12]) mi = i;
        eh = lv && (mi >= 0);
        ep = eh ? {mppn[mi], va[11:0]} : 32'h0;
        chk(tag, "hit", {31'b0, lk_hit}, {31'b0, eh});
        chk(tag, "miss_exc", {31'b0, lk_miss_exc}, {31'b0, lv && (mi < 0)});
        chk(tag, "paddr", lk_paddr, ep);
        chk(tag, "ref", {31'b0, lk_ref}, {31'b0, eh ? mref[mi] : 1'b0});
        chk(tag, "dirty", {31'b0, lk_dirty}, {31'b0, eh ? mdirty[mi] : 1'b0});
        // victim from pre-update state
        vic = -1; kind = 0;
        if (fv) begin
            fi = -1;
            for (int i = 0; i < N; i++) if (mv[i] && mtag[i] == fvpn) fi = i;
            if (fi >= 0) vic = fi;
            else begin
                for (int i = N - 1; i >= 0; i--) if (!mv[i]) vic = i;
                if (vic < 0) begin
                    kind = 1;
                    for (int k = N - 1; k >= 0; k--)
                        if (!mref[(mptr + k) % N]) vic = (mptr + k) % N;
                    if (vic < 0) vic = mptr;
                end
            end
        end
        @(posedge clk);
        if (rc) for (int i = 0; i < N; i++) mref[i] = 1'b0;
        if (eh) begin
            mref[mi] = 1'b1;
            if (lw) mdirty[mi] = 1'b1;
        end
        if (fv) begin
            mv[vic] = 1'b1; mtag[vic] = fvpn; mppn[vic] = fppn;
            mref[vic] = 1'b0; mdirty[vic] = 1'b0;
            if (kind == 1) mptr = (vic + 1) % N;
        end
        @(negedge clk);
    endtask

    task automatic look(string tag, bit lw, logic [31:0] va);
        step(tag, 1'b1, lw, va, 1'b0, 20'h0, 20'h0, 1'b0);
    endtask

    task automatic fill(string tag, logic [19:0] vpn, logic [19:0] ppn);
        step(tag, 1'b0, 1'b0, 32'h0, 1'b1, vpn, ppn, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mtag[i] = 0; mppn[i] = 0; mref[i] = 0; mdirty[i] = 0;
        end
        mptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: empty after reset
        look("R12", 1'b0, 32'h0010_0abc);
        look("R12", 1'b1, 32'h0000_0000);
        // R13: idle lookup gives zeros even with matching address later
        step("R13", 1'b0, 1'b0, 32'h0010_0000, 1'b0, 20'h0, 20'h0, 1'b0);
        // R7: fill all entries into empty slots
        for (int i = 0; i < N; i++) fill("R7", 20'h00100 + 20'(i), 20'h0a000 + 20'(i * 3));
        // R2 / R1: each entry hits with its own offset
        for (int i = 0; i < N; i++) look("R2", 1'b0, {20'h00100 + 20'(i), 12'(i * 257)});
        look("R1", 1'b0, 32'h0010_7fff);
        // R5: writes mark modified, reads show it
        look("R5", 1'b1, 32'h0010_2004);
        look("R5", 1'b0, 32'h0010_2008);
        look("R5", 1'b0, 32'h0010_3000);
        // R9: all used -> pointer entry 0 replaced
        fill("R9", 20'h00200, 20'h0bbbb);
        look("R3", 1'b1, 32'h0010_0123);
        look("R9", 1'b0, 32'h0020_0123);
        // R6: clear with a same-cycle hit on entry 5
        step("R6", 1'b1, 1'b0, 32'h0010_5000, 1'b0, 20'h0, 20'h0, 1'b1);
        look("R6", 1'b0, 32'h0010_6000);
        look("R6", 1'b0, 32'h0010_5000);
        // R4: touch entries 1..3, then scan from pointer 1 skips them
        look("R4", 1'b0, 32'h0010_1000);
        look("R4", 1'b0, 32'h0010_2000);
        look("R4", 1'b0, 32'h0010_3000);
        look("R4", 1'b0, 32'h0010_1000);
        fill("R8", 20'h00201, 20'h0cccc);
        look("R8", 1'b0, 32'h0010_4000);
        look("R8", 1'b0, 32'h0020_1000);
        // R10: refill of a held page replaces in place
        look("R10", 1'b1, 32'h0020_0000);
        fill("R10", 20'h00200, 20'h0dddd);
        look("R10", 1'b0, 32'h0020_0040);
        // R11: fill and hit on same entry in one cycle
        look("R11", 1'b1, 32'h0010_7000);
        step("R11", 1'b1, 1'b1, 32'h0010_7000, 1'b1, 20'h00107, 20'h0eeee, 1'b0);
        look("R11", 1'b0, 32'h0010_7000);
        // R13: random traffic over a small page space
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step("R13", r[0] | r[1], r[2], {20'(r[13:8] % 40), r[31:20]},
                 (r[5:3] == 3'd0), 20'(r[19:14] % 40), 20'(r[31:16]), (r[7:6] == 2'd0) && r[4]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule